// File: doc/BRIEF.md
# Data and Stack Segment Load Protection Checker

This block decides whether a descriptor may be placed into one of the data segment registers (DS, ES, FS, GS) or the stack segment register (SS). A request carries the current privilege level, the full 16-bit selector, the descriptor's access-rights byte and a target code. The block captures the request, works out the effective privilege level, and then runs three checks in a fixed order: type, privilege, presence. It reports a verdict once. The verdict is either a grant, which returns the access byte with its accessed bit set, or a fault with an exception vector: 13 for a protection fault, 12 for a stack fault, or 11 for a not-present segment.

The control is a five-state machine. ST_IDLE waits for `req_valid`. ST_TYPE checks the null selector and the descriptor type. ST_PRIV compares privilege levels. ST_PRES tests the present bit. ST_REPORT shows the verdict for exactly one cycle.

The transitions are as follows. ST_IDLE goes to ST_TYPE when a request is accepted. ST_TYPE goes to ST_REPORT when the selector is null or the type is rejected, and to ST_PRIV otherwise. ST_PRIV goes to ST_REPORT on a privilege failure, and to ST_PRES otherwise. ST_PRES always goes to ST_REPORT. ST_REPORT always goes to ST_IDLE. Only the first failing check is reported.

Top module: `seg_load_checker`

## Requirements
- R1: After reset, `busy`, `done`, `grant`, `fault` and `set_accessed` are 0, and `fault_vec` and `arb_out` read 0.
- R2: A request is taken only while `busy` is 0. From the next cycle `busy` stays 1 through the report cycle. `req_valid` and request data presented while busy are ignored and do not change the verdict.
- R3: Access byte layout: bit 7 present, bits 6:5 descriptor level, bit 4 code/data (1) versus system (0), bit 3 executable, bit 2 expand-down/conforming, bit 1 writable/readable, bit 0 accessed. For target codes 0..3 (DS, ES, FS, GS), the type passes only for a code/data descriptor that is data (bit 3 = 0) or readable code (bit 3 = 1 and bit 1 = 1). Any other type gives vector 13.
- R4: The effective level is the larger of the current level and the selector's bits 1:0. For a data-register load of data or non-conforming code, a descriptor level numerically below the effective level gives vector 13. Readable conforming code skips this test.
- R5: For target code 4 (SS), the type passes only for writable data: bit 4 = 1, bit 3 = 0 and bit 1 = 1. Any other type gives vector 13.
- R6: For SS, the selector's bits 1:0 and the descriptor level must both equal the current level. Otherwise the result is vector 13.
- R7: A descriptor that passes type and privilege but has bit 7 = 0 gives vector 12 for SS and vector 11 for a data register. Type is checked first, then privilege, then presence, and only the first failure is reported.
- R8: A null selector (bits 15:2 all zero) targeting a data register is granted with `set_accessed` = 0 and `arb_out` equal to the input byte. A null selector targeting SS gives vector 13.
- R9: On a grant of a non-null selector, `arb_out` is the input byte with bit 0 set, `set_accessed` = 1 and `fault_vec` = 0. On a fault, `arb_out` is the input byte unchanged.
- R10: Counting the accepting edge as 0, `done` appears 2 cycles later for a null-selector or type verdict, 3 cycles later for a privilege fault, and 4 cycles later otherwise. It lasts one cycle, and exactly one of `grant` and `fault` is 1 with it.
- R11: Target codes 5..7 are rejected at the type step with vector 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_cpl | input | 2 | Current privilege level |
| req_sel | input | 16 | Selector being loaded |
| req_arb | input | 8 | Descriptor access-rights byte |
| req_tgt | input | 3 | Target: 0..3 data registers, 4 SS, 5..7 invalid |
| busy | output | 1 | A request is in progress |
| done | output | 1 | Verdict valid this cycle |
| grant | output | 1 | Load allowed |
| fault | output | 1 | Load refused |
| fault_vec | output | 8 | Exception vector on fault, else 0 |
| arb_out | output | 8 | Access byte to write back |
| set_accessed | output | 1 | Accessed bit must be written back |

## Verification
Several checks can fail on the same descriptor. The case that matters is a not-present segment that also breaks the type or privilege rule. The bench builds such descriptors and judges the result by the vector and by the cycle in which `done` rises: the earlier failure must win, and it must be reported at its own, shorter latency. The bench also holds `req_valid` high with different request data while the report cycle is shown. The expected verdict and the return to idle must be exactly those of the first request.

// File: rtl/seg_chk_pkg.sv
`timescale 1ns/1ps
package seg_chk_pkg;
    localparam int PL_W  = 2;
    localparam int TGT_W = 3;

    localparam logic [TGT_W-1:0] TGT_LAST_DATA = 3'd3;
    localparam logic [TGT_W-1:0] TGT_STACK     = 3'd4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TYPE,
        ST_PRIV,
        ST_PRES,
        ST_REPORT
    } chk_state_e;

    typedef enum logic [1:0] {
        VRD_GRANT,
        VRD_GP,
        VRD_STACK,
        VRD_NOTP
    } verdict_e;
endpackage

// File: rtl/seg_arb_decode.sv
`timescale 1ns/1ps
module seg_arb_decode
    import seg_chk_pkg::*;
#(
    parameter int ARB_W = 8
) (
    input  logic [ARB_W-1:0] arb_i,
    output logic             present_o,
    output logic [PL_W-1:0]  dpl_o,
    output logic             is_data_o,
    output logic             is_code_o,
    output logic             conforming_o,
    output logic             readable_o,
    output logic             writable_o
);
    localparam int P_BIT   = 7;
    localparam int DPL_LSB = 5;
    localparam int S_BIT   = 4;
    localparam int E_BIT   = 3;
    localparam int C_BIT   = 2;
    localparam int RW_BIT  = 1;

    logic code_or_data;

    always_comb begin
        code_or_data = arb_i[S_BIT];
        present_o    = arb_i[P_BIT];
        dpl_o        = arb_i[DPL_LSB +: PL_W];
        is_data_o    = code_or_data && !arb_i[E_BIT];
        is_code_o    = code_or_data &&  arb_i[E_BIT];
        conforming_o = is_code_o && arb_i[C_BIT];
        readable_o   = is_code_o && arb_i[RW_BIT];
        writable_o   = is_data_o && arb_i[RW_BIT];
    end
endmodule

// File: rtl/seg_rule_eval.sv
`timescale 1ns/1ps
module seg_rule_eval
    import seg_chk_pkg::*;
#(
    parameter bit CONF_EXEMPT = 1'b1
) (
    input  logic [TGT_W-1:0] tgt_i,
    input  logic [PL_W-1:0]  cpl_i,
    input  logic [PL_W-1:0]  rpl_i,
    input  logic [PL_W-1:0]  dpl_i,
    input  logic             is_data_i,
    input  logic             is_code_i,
    input  logic             conforming_i,
    input  logic             readable_i,
    input  logic             writable_i,
    output logic             tgt_data_o,
    output logic             tgt_stack_o,
    output logic             type_ok_o,
    output logic             priv_ok_o
);
    logic [PL_W-1:0] epl;
    logic            data_priv_ok;
    logic            stack_priv_ok;
    logic            skip_data_priv;

    always_comb begin
        tgt_data_o  = (tgt_i <= TGT_LAST_DATA);
        tgt_stack_o = (tgt_i == TGT_STACK);
        epl         = (cpl_i > rpl_i) ? cpl_i : rpl_i;
    end

    generate
        if (CONF_EXEMPT) begin : g_conf_exempt
            always_comb skip_data_priv = conforming_i && readable_i;
        end else begin : g_conf_checked
            always_comb skip_data_priv = 1'b0;
        end
    endgenerate

    always_comb begin
        data_priv_ok  = skip_data_priv || (dpl_i >= epl);
        stack_priv_ok = (rpl_i == cpl_i) && (dpl_i == cpl_i);

        if (tgt_data_o)
            type_ok_o = is_data_i || (is_code_i && readable_i);
        else if (tgt_stack_o)
            type_ok_o = writable_i;
        else
            type_ok_o = 1'b0;

        if (tgt_stack_o)
            priv_ok_o = stack_priv_ok;
        else
            priv_ok_o = data_priv_ok;
    end
endmodule

// File: rtl/seg_load_checker.sv
`timescale 1ns/1ps
module seg_load_checker
    import seg_chk_pkg::*;
#(
    parameter int         SEL_W       = 16,
    parameter int         ARB_W       = 8,
    parameter int         VEC_W       = 8,
    parameter int         VEC_GP      = 13,
    parameter int         VEC_STACK   = 12,
    parameter int         VEC_NOTP    = 11,
    parameter bit         CONF_EXEMPT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_cpl,
    input  logic [SEL_W-1:0] req_sel,
    input  logic [ARB_W-1:0] req_arb,
    input  logic [2:0]       req_tgt,
    output logic             busy,
    output logic             done,
    output logic             grant,
    output logic             fault,
    output logic [VEC_W-1:0] fault_vec,
    output logic [ARB_W-1:0] arb_out,
    output logic             set_accessed
);
    localparam int IDX_LSB = PL_W;
    localparam int IDX_W   = SEL_W - IDX_LSB;
    localparam logic [VEC_W-1:0] V_GP = VEC_W'(VEC_GP);
    localparam logic [VEC_W-1:0] V_SS = VEC_W'(VEC_STACK);
    localparam logic [VEC_W-1:0] V_NP = VEC_W'(VEC_NOTP);

    chk_state_e state_q, state_d;
    verdict_e   vrd_q;

    logic [PL_W-1:0]  cpl_q, rpl_q;
    logic [ARB_W-1:0] arb_q;
    logic [TGT_W-1:0] tgt_q;
    logic             null_q;

    logic            present, is_data, is_code, conforming, readable, writable;
    logic [PL_W-1:0] dpl;
    logic            tgt_data, tgt_stack, type_ok, priv_ok;

    seg_arb_decode #(.ARB_W(ARB_W)) u_decode (
        .arb_i        (arb_q),
        .present_o    (present),
        .dpl_o        (dpl),
        .is_data_o    (is_data),
        .is_code_o    (is_code),
        .conforming_o (conforming),
        .readable_o   (readable),
        .writable_o   (writable)
    );

    seg_rule_eval #(.CONF_EXEMPT(CONF_EXEMPT)) u_rules (
        .tgt_i        (tgt_q),
        .cpl_i        (cpl_q),
        .rpl_i        (rpl_q),
        .dpl_i        (dpl),
        .is_data_i    (is_data),
        .is_code_i    (is_code),
        .conforming_i (conforming),
        .readable_i   (readable),
        .writable_i   (writable),
        .tgt_data_o   (tgt_data),
        .tgt_stack_o  (tgt_stack),
        .type_ok_o    (type_ok),
        .priv_ok_o    (priv_ok)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_TYPE;
            ST_TYPE:   state_d = (null_q || !type_ok) ? ST_REPORT : ST_PRIV;
            ST_PRIV:   state_d = priv_ok ? ST_PRES : ST_REPORT;
            ST_PRES:   state_d = ST_REPORT;
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Request capture and verdict register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpl_q  <= '0;
            rpl_q  <= '0;
            arb_q  <= '0;
            tgt_q  <= '0;
            null_q <= 1'b0;
            vrd_q  <= VRD_GRANT;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    cpl_q  <= req_cpl;
                    rpl_q  <= req_sel[PL_W-1:0];
                    arb_q  <= req_arb;
                    tgt_q  <= req_tgt;
                    null_q <= (req_sel[SEL_W-1:IDX_LSB] == IDX_W'(0));
                    vrd_q  <= VRD_GRANT;
                end
                ST_TYPE: begin
                    if (null_q)
                        vrd_q <= tgt_data ? VRD_GRANT : VRD_GP;
                    else if (!type_ok)
                        vrd_q <= VRD_GP;
                end
                ST_PRIV: if (!priv_ok) vrd_q <= VRD_GP;
                ST_PRES: begin
                    if (!present)
                        vrd_q <= tgt_stack ? VRD_STACK : VRD_NOTP;
                    else
                        vrd_q <= VRD_GRANT;
                end
                ST_REPORT: ;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy         = (state_q != ST_IDLE);
        done         = (state_q == ST_REPORT);
        grant        = done && (vrd_q == VRD_GRANT);
        fault        = done && (vrd_q != VRD_GRANT);
        set_accessed = grant && !null_q;
        fault_vec    = '0;
        arb_out      = '0;
        if (done) begin
            unique case (vrd_q)
                VRD_GRANT: fault_vec = '0;
                VRD_GP:    fault_vec = V_GP;
                VRD_STACK: fault_vec = V_SS;
                VRD_NOTP:  fault_vec = V_NP;
                default:   fault_vec = V_GP;
            endcase
            arb_out = set_accessed ? (arb_q | ARB_W'(1)) : arb_q;
        end
    end

    // Assertions
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r10_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (grant != fault));
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!done && fault_vec == '0));
    a_r2_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(arb_q) && $stable(tgt_q) && $stable(cpl_q)));
    a_r7_notp_absent: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && (fault_vec == V_NP || fault_vec == V_SS)) |-> !arb_out[ARB_W-1]);
    a_r6_stack_level: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && tgt_stack && !null_q) |-> (arb_out[6:5] == cpl_q && rpl_q == cpl_q));
    a_r9_accessed_set: assert property (@(posedge clk) disable iff (!rst_n)
        set_accessed |-> arb_out[0]);
    a_r11_bad_target: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !tgt_data && !tgt_stack) |-> (fault && fault_vec == V_GP));
endmodule

// File: tb/seg_load_checker_tb.sv
`timescale 1ns/1ps
module seg_load_checker_tb_top;
    localparam time CLK_P = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_cpl = '0;
    logic [15:0] req_sel = '0;
    logic [7:0] req_arb = '0;
    logic [2:0] req_tgt = '0;
    logic       busy, done, grant, fault, set_accessed;
    logic [7:0] fault_vec, arb_out;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    seg_load_checker dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cpl(req_cpl),
        .req_sel(req_sel), .req_arb(req_arb), .req_tgt(req_tgt),
        .busy(busy), .done(done), .grant(grant), .fault(fault),
        .fault_vec(fault_vec), .arb_out(arb_out), .set_accessed(set_accessed)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference: latency, grant, vector, returned byte, accessed flag
    task automatic model(input int tgt, input int cpl, input int sel, input int arb,
                         output int lat, output int g, output int vec,
                         output int aout, output int sacc);
        int rpl, dpl, epl;
        bit nul, p, s, e, b2, b1, dreg, sreg, tok, pok;
        rpl = sel % 4;
        nul = (sel / 4) == 0;
        p = arb[7]; dpl = (arb / 32) % 4; s = arb[4]; e = arb[3]; b2 = arb[2]; b1 = arb[1];
        epl = (cpl > rpl) ? cpl : rpl;
        dreg = tgt <= 3;
        sreg = tgt == 4;
        g = 0; vec = 13; aout = arb; sacc = 0;
        if (nul) begin
            lat = 2;
            if (dreg) begin g = 1; vec = 0; end
            return;
        end
        if (dreg)      tok = s && (!e || b1);
        else if (sreg) tok = s && !e && b1;
        else           tok = 0;
        if (!tok) begin lat = 2; return; end
        if (sreg) pok = (rpl == cpl) && (dpl == cpl);
        else      pok = (e && b2) ? 1'b1 : (dpl >= epl);
        if (!pok) begin lat = 3; return; end
        lat = 4;
        if (!p) vec = sreg ? 12 : 11;
        else begin g = 1; vec = 0; aout = arb | 1; sacc = 1; end
    endtask

    // Drives one request and compares outputs on every cycle until idle again
    task automatic run(input string req, input int tgt, input int cpl, input int sel,
                       input int arb, input bit hold);
        int lat, g, vec, aout, sacc;
        model(tgt, cpl, sel, arb, lat, g, vec, aout, sacc);
        @(negedge clk);
        chk(req, "idle before request", busy, 0);
        req_valid = 1'b1; req_tgt = tgt[2:0]; req_cpl = cpl[1:0];
        req_sel = sel[15:0]; req_arb = arb[7:0];
        for (int k = 1; k <= lat; k++) begin
            @(negedge clk);
            if (!hold || k == lat) req_valid = 1'b0;
            if (hold) begin
                req_arb = 8'h00; req_tgt = 3'd5; req_sel = 16'h0013;
            end
            chk(req, "busy", busy, 1);
            chk(req, "done timing R10", done, (k == lat) ? 1 : 0);
            if (k == lat) begin
                chk(req, "grant", grant, g);
                chk(req, "fault R10", fault, 1 - g);
                chk(req, "vector", fault_vec, vec);
                chk(req, "arb_out R9", arb_out, aout);
                chk(req, "set_accessed R9", set_accessed, sacc);
            end
        end
        @(negedge clk);
        chk(req, "back to idle R2", busy, 0);
        chk(req, "no done when idle R10", done, 0);
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R1", "grant", grant, 0);
        chk("R1", "fault", fault, 0);
        chk("R1", "fault_vec", fault_vec, 0);
        chk("R1", "arb_out", arb_out, 0);
        chk("R1", "set_accessed", set_accessed, 0);
        rst_n = 1'b1;

        // R3 data register type rules
        run("R3 DS writable data",      0, 3, 16'h0023, 8'hF2, 0);
        run("R3 DS system descriptor",  0, 0, 16'h0020, 8'h82, 0);
        run("R3 ES unreadable code",    1, 0, 16'h0020, 8'h98, 0);
        run("R3 ES readonly data",      1, 0, 16'h0028, 8'h90, 0);
        // R4 effective level
        run("R4 FS code rpl too weak",  2, 0, 16'h002B, 8'h9A, 0);
        run("R4 GS conforming exempt",  3, 3, 16'h0033, 8'h9E, 0);
        run("R4 DS dpl equal epl",      0, 1, 16'h0042, 8'hD2, 0);
        run("R4 DS rpl raises epl",     0, 1, 16'h0043, 8'hD2, 0);
        run("R4 DS cpl above dpl",      0, 3, 16'h0040, 8'hB2, 0);
        // R5 R6 stack rules
        run("R5 SS writable data",      4, 0, 16'h0010, 8'h92, 0);
        run("R5 SS readonly data",      4, 0, 16'h0010, 8'h90, 0);
        run("R5 SS code segment",       4, 0, 16'h0010, 8'h9A, 0);
        run("R6 SS rpl mismatch",       4, 0, 16'h0011, 8'h92, 0);
        run("R6 SS dpl mismatch",       4, 2, 16'h0012, 8'hB2, 0);
        // R7 presence and ordering
        run("R7 DS not present",        0, 0, 16'h0018, 8'h12, 0);
        run("R7 SS not present",        4, 1, 16'h0019, 8'h32, 0);
        run("R7 priv before present",   0, 3, 16'h001B, 8'h12, 0);
        run("R7 type before present",   4, 0, 16'h0018, 8'h10, 0);
        // R8 null selector
        run("R8 DS null",               0, 2, 16'h0002, 8'h00, 0);
        run("R8 SS null",               4, 0, 16'h0000, 8'h92, 0);
        // R9 already accessed
        run("R9 GS already accessed",   3, 0, 16'h0050, 8'h93, 0);
        // R11 invalid targets
        run("R11 target 5",             5, 0, 16'h0050, 8'h92, 0);
        run("R11 target 7",             7, 0, 16'h0050, 8'h92, 0);
        // R2 request held while busy
        run("R2 held valid",            0, 0, 16'h0060, 8'h92, 1);
        run("R2 held valid short",      4, 0, 16'h0000, 8'h92, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule